// File: doc/BRIEF.md
# Masked Control/Status Register Bank

This block holds the processor's 32-bit control and status registers and serves software accesses to them. Each request carries an operation selector, a 14-bit register index, a data word and a mask word. One of three things happens: a plain read, a full write, or an exchange that changes only the bits picked by the mask word. Every register has its own set of bits that software may change. Bits outside that set keep their value whatever the request carries.

Whatever the operation, the value returned is the content the register held before the request took effect. The result appears one clock after the request is sampled. Write-one action bits are never stored and always read as zero. An index that names no register returns zero and raises an error flag for that one response. The hardware-side updates (timer countdown, exception capture, translation lookups) sit outside this block.

Top module: `ctl_reg_bank`

## Requirements
- R1: A request with `req_sel` = 0 is a read. It leaves every register unchanged and returns the addressed register's content.
- R2: A request with `req_sel` = 1 is a full write. On each writable bit of the addressed register it stores the matching bit of `req_wdata`.
- R3: A request with `req_sel` of 2 or more is an exchange. Only bits that are set in `req_mask` and are also writable take the value from `req_wdata`. Every other bit keeps its old value.
- R4: For a request sampled at a clock edge, `rsp_rdata` shows after that edge the register's value from before the request. This holds for reads, writes and exchanges alike.
- R5: After synchronous active-low reset, the mode register at index 0x000 reads 0x00000008 (direct-address bit 3 set). Every other register reads 0, and `rsp_rdata` and `rsp_bad_addr` are 0.
- R6: The registers at 0x01B, 0x020, 0x042 and 0x098 have no writable bits. Writes and exchanges leave them at zero.
- R7: Bit 0 of the register at 0x044 and bit 1 of the register at 0x060 are write-one action bits. They are not writable and read back as zero after a one is written to them.
- R8: A request to an index outside the register list returns 0 on `rsp_rdata` and sets `rsp_bad_addr` for that response. It changes no register.
- R9: In a cycle with no request, `rsp_rdata` keeps its last value and `rsp_bad_addr` drops to 0 after the next edge.
- R10: The writable masks are fixed per register:
  - all 32 bits: 0x006, 0x007, 0x030–0x033, 0x040
  - 0xFFFFFFC0: 0x00C, 0x088
  - 0xFFFFF000: 0x019, 0x01A
  - 0xFFFFE000: 0x011, 0x012
  - 0xFFFFFF7F: 0x013
  - 0xBF00FFFF: 0x010
  - 0x7FFFFFFF: 0x041
  - 0xEE000039: 0x180, 0x181
  - 0x1BFF: 0x004
  - 0x3FF: 0x018
  - 0x1FF: 0x000
  - 0x7: 0x001
  - 0x4: 0x060
  - 0x3: 0x005
  - 0x1: 0x002
  - 0: 0x01B, 0x020, 0x042, 0x044, 0x098

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_sel | input | 5 | Operation selector: 0 read, 1 write, 2 or more exchange |
| req_addr | input | 14 | Register index |
| req_wdata | input | 32 | Data to write or exchange |
| req_mask | input | 32 | Bit select for an exchange |
| rsp_rdata | output | 32 | Pre-access value of the addressed register |
| rsp_bad_addr | output | 1 | The last request named no register |

## Verification
Some properties are checked on every cycle. Bits outside a register's writable mask never move. A register with no write enable holds its value. An exchange leaves alone the bits its mask excludes. The decoder hits at most one register. An error response carries zero data, and idle cycles hold the response and clear the flag.

Other behaviour shows only in the bench's scenarios. These are the exact per-register masks, the reset contents, the returned pre-write values, and whether an invalid index leaves the registers unchanged. The bench covers them with a reference model under random mixed traffic and with directed cases.

// File: rtl/crf_pkg.sv
// Package: shared constants for the control register bank.
// Holds the register index list, the per-register writable masks and the
// reset values. Every table is a function of a slot number, so the top can
// build its slots in a generate loop. Assumes NUM_SLOTS slots numbered 0..29.
package crf_pkg;

    localparam int NUM_SLOTS = 30;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_XCHG  = 2'd2
    } crf_op_e;

    // Register index of each slot
    function automatic logic [31:0] slot_addr(input int s);
        logic [31:0] a;
        case (s)
            0:  a = 32'h000;  // mode
            1:  a = 32'h001;  // saved mode
            2:  a = 32'h002;  // extension enable
            3:  a = 32'h004;  // exception config
            4:  a = 32'h005;  // exception status
            5:  a = 32'h006;  // return address
            6:  a = 32'h007;  // faulting address
            7:  a = 32'h00C;  // exception entry
            8:  a = 32'h010;  // translation index
            9:  a = 32'h011;  // translation high
            10: a = 32'h012;  // translation low 0
            11: a = 32'h013;  // translation low 1
            12: a = 32'h018;  // space id
            13: a = 32'h019;  // directory low half
            14: a = 32'h01A;  // directory high half
            15: a = 32'h01B;  // directory selected
            16: a = 32'h020;  // core id
            17: a = 32'h030;  // scratch 0
            18: a = 32'h031;  // scratch 1
            19: a = 32'h032;  // scratch 2
            20: a = 32'h033;  // scratch 3
            21: a = 32'h040;  // timer id
            22: a = 32'h041;  // timer config
            23: a = 32'h042;  // timer value
            24: a = 32'h044;  // timer clear
            25: a = 32'h060;  // link control
            26: a = 32'h088;  // refill entry
            27: a = 32'h098;  // cache tag
            28: a = 32'h180;  // mapping window 0
            default: a = 32'h181;  // mapping window 1
        endcase
        return a;
    endfunction

    // Contiguous bit field mask [hi:lo], computed in 64 bits so hi=31 is safe
    function automatic logic [31:0] fld(input int hi, input int lo);
        logic [63:0] m;
        m = ((64'd1 << (hi + 1)) - 64'd1) & ~((64'd1 << lo) - 64'd1);
        return m[31:0];
    endfunction

    // Software-writable bits of each slot; write-one bits are excluded
    function automatic logic [31:0] slot_wmask(input int s, input int idx_w,
                                               input int tmr_w, input int phys_w);
        logic [31:0] m;
        case (s)
            0:  m = fld(8, 0);
            1:  m = fld(2, 0);
            2:  m = fld(0, 0);
            3:  m = fld(12, 11) | fld(9, 0);
            4:  m = fld(1, 0);
            5, 6, 17, 18, 19, 20, 21: m = fld(31, 0);
            7, 26: m = fld(31, 6);
            8:  m = fld(31, 31) | fld(29, 24) | fld(idx_w - 1, 0);
            9, 10: m = fld(31, 13);
            11: m = fld(phys_w - 5, 8) | fld(6, 0);
            12: m = fld(9, 0);
            13, 14: m = fld(31, 12);
            22: m = fld(tmr_w - 1, 0);
            25: m = fld(2, 2);
            28, 29: m = fld(31, 29) | fld(27, 25) | fld(5, 3) | fld(0, 0);
            default: m = 32'h0;
        endcase
        return m;
    endfunction

    // Reset content: only the direct-address bit of the mode register is set
    function automatic logic [31:0] slot_rst(input int s);
        return (s == 0) ? 32'h0000_0008 : 32'h0;
    endfunction

endpackage

// File: rtl/crf_addr_decode.sv
// Module: crf_addr_decode
// Compares the request index against every slot's index and gives a one-hot
// hit vector and an any-hit flag. Purely combinational; clk/rst_n feed only
// the assertion. Assumes the slot index list holds no duplicates.
module crf_addr_decode
    import crf_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int N      = NUM_SLOTS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    output logic [N-1:0]      hit,
    output logic              hit_any
);

    // One comparator per slot
    for (genvar g = 0; g < N; g++) begin : g_cmp
        localparam logic [31:0] SLOT_A = slot_addr(g);
        assign hit[g] = (addr == SLOT_A[ADDR_W-1:0]);
    end

    // Any slot hit
    assign hit_any = |hit;

    // R8: one index selects at most one register
    p_single_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));

endmodule

// File: rtl/crf_slot.sv
// Module: crf_slot
// One register of the bank. It merges a full write or a masked exchange and
// then protects every bit outside WMASK. Assumes wr_en is high only for a
// valid, matching write or exchange request.
module crf_slot #(
    parameter int          DATA_W  = 32,
    parameter logic [31:0] WMASK   = 32'hFFFF_FFFF,
    parameter logic [31:0] RST_VAL = 32'h0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              op_xchg,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] mask,
    output logic [DATA_W-1:0] q
);

    localparam logic [DATA_W-1:0] WM  = WMASK[DATA_W-1:0];
    localparam logic [DATA_W-1:0] RST = RST_VAL[DATA_W-1:0];

    logic [DATA_W-1:0] merged;
    logic [DATA_W-1:0] nxt;

    // Select the incoming bits: full word, or mask-picked bits over old value
    always_comb begin
        merged = op_xchg ? ((q & ~mask) | (wdata & mask)) : wdata;
        nxt    = (q & ~WM) | (merged & WM);
    end

    // Register state with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= RST;
        end else if (wr_en) begin
            q <= nxt;
        end
    end

    // R6 / R10: bits outside the writable mask never move
    p_fixed_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((q ^ $past(q)) & ~WM) == '0);

    // R1: no write enable, no change
    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(q));

    // R3: an exchange leaves bits with a clear mask alone
    p_xchg_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && op_xchg) |=> ((q ^ $past(q)) & ~$past(mask)) == '0);

endmodule

// File: rtl/crf_read_mux.sv
// Module: crf_read_mux
// AND-OR selection of one slot's value by a one-hot vector. An all-zero
// select gives zero. Assumes sel is one-hot or zero.
module crf_read_mux #(
    parameter int N = 30,
    parameter int W = 32
) (
    input  logic [N-1:0]        sel,
    input  logic [N-1:0][W-1:0] din,
    output logic [W-1:0]        dout
);

    // OR together the selected slot values
    always_comb begin
        dout = '0;
        for (int i = 0; i < N; i++) begin
            dout = dout | (din[i] & {W{sel[i]}});
        end
    end

endmodule

// File: rtl/ctl_reg_bank.sv
// Module: ctl_reg_bank (top)
// Bank of control/status registers with read, full write and masked exchange.
// A request is sampled at a clock edge. The pre-access value of the addressed
// register appears on rsp_rdata after that edge. An unknown index answers
// zero with rsp_bad_addr set. Assumes DATA_W <= 32 and TMR_W <= 32.
module ctl_reg_bank
    import crf_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int DATA_W = 32,
    parameter int SEL_W  = 5,
    parameter int IDX_W  = 16,
    parameter int TMR_W  = 31,
    parameter int PHYS_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [SEL_W-1:0]  req_sel,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] req_mask,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_bad_addr
);

    localparam int N = NUM_SLOTS;

    logic [N-1:0]             hit;
    logic                     hit_any;
    logic [N-1:0][DATA_W-1:0] slot_q;
    logic [DATA_W-1:0]        old_val;
    crf_op_e                  op;

    // Map the selector field onto the three operations
    always_comb begin
        if (req_sel == '0)                    op = OP_READ;
        else if (req_sel == SEL_W'(1))        op = OP_WRITE;
        else                                  op = OP_XCHG;
    end

    crf_addr_decode #(.ADDR_W(ADDR_W), .N(N)) dec_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (req_addr),
        .hit     (hit),
        .hit_any (hit_any)
    );

    // One register per slot, mask and reset value from the package tables
    for (genvar g = 0; g < N; g++) begin : g_slot
        crf_slot #(
            .DATA_W  (DATA_W),
            .WMASK   (slot_wmask(g, IDX_W, TMR_W, PHYS_W)),
            .RST_VAL (slot_rst(g))
        ) slot_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (req_valid && hit[g] && (op != OP_READ)),
            .op_xchg (op == OP_XCHG),
            .wdata   (req_wdata),
            .mask    (req_mask),
            .q       (slot_q[g])
        );
    end

    crf_read_mux #(.N(N), .W(DATA_W)) mux_i (
        .sel  (hit),
        .din  (slot_q),
        .dout (old_val)
    );

    // Capture the pre-access value and the invalid-index flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_rdata    <= '0;
            rsp_bad_addr <= 1'b0;
        end else begin
            rsp_bad_addr <= req_valid && !hit_any;
            if (req_valid) begin
                rsp_rdata <= hit_any ? old_val : '0;
            end
        end
    end

    // R8: an error response carries zero data
    p_bad_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_bad_addr |-> (rsp_rdata == '0));

    // R9: idle cycle clears the flag
    p_idle_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_bad_addr);

    // R9: idle cycle holds the returned data
    p_idle_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(rsp_rdata));

    // R5: first cycle out of reset shows a cleared response
    p_reset_resp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (rsp_rdata == '0 && !rsp_bad_addr));

endmodule

// File: tb/ctl_reg_bank_tb_top.sv
`timescale 1ns/1ps
module ctl_reg_bank_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [4:0]  req_sel = '0;
    logic [13:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] req_mask = '0;
    logic [31:0] rsp_rdata;
    logic        rsp_bad_addr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] model [30];

    always #2.5 clk = ~clk;

    ctl_reg_bank dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sel(req_sel),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
        .rsp_rdata(rsp_rdata), .rsp_bad_addr(rsp_bad_addr)
    );

    // Index list from R10/R5/R6/R7
    function automatic logic [13:0] b_addr(input int s);
        logic [13:0] t [30] = '{14'h000, 14'h001, 14'h002, 14'h004, 14'h005, 14'h006,
            14'h007, 14'h00C, 14'h010, 14'h011, 14'h012, 14'h013, 14'h018, 14'h019,
            14'h01A, 14'h01B, 14'h020, 14'h030, 14'h031, 14'h032, 14'h033, 14'h040,
            14'h041, 14'h042, 14'h044, 14'h060, 14'h088, 14'h098, 14'h180, 14'h181};
        return t[s];
    endfunction

    // Writable masks from R10
    function automatic logic [31:0] b_mask(input int s);
        logic [31:0] t [30] = '{32'h1FF, 32'h7, 32'h1, 32'h1BFF, 32'h3, 32'hFFFFFFFF,
            32'hFFFFFFFF, 32'hFFFFFFC0, 32'hBF00FFFF, 32'hFFFFE000, 32'hFFFFE000,
            32'hFFFFFF7F, 32'h3FF, 32'hFFFFF000, 32'hFFFFF000, 32'h0, 32'h0,
            32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF,
            32'h7FFFFFFF, 32'h0, 32'h0, 32'h4, 32'hFFFFFFC0, 32'h0, 32'hEE000039,
            32'hEE000039};
        return t[s];
    endfunction

    function automatic int b_slot(input logic [13:0] a);
        for (int s = 0; s < 30; s++) if (b_addr(s) == a) return s;
        return -1;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // Issue one request, return response; update model (R1..R4, R8)
    task automatic do_op(input logic [4:0] sel, input logic [13:0] a,
                         input logic [31:0] wd, input logic [31:0] mk, input string tag);
        int s;
        logic [31:0] old, mrg, wm;
        s = b_slot(a);
        @(negedge clk);
        req_valid = 1'b1; req_sel = sel; req_addr = a; req_wdata = wd; req_mask = mk;
        @(negedge clk);
        req_valid = 1'b0;
        if (s < 0) begin
            chk({tag, " R8 data"}, rsp_rdata, 32'h0);
            chk({tag, " R8 flag"}, {31'h0, rsp_bad_addr}, 32'h1);
        end else begin
            old = model[s];
            wm  = b_mask(s);
            chk({tag, " R4 old value"}, rsp_rdata, old);
            chk({tag, " R8 flag low"}, {31'h0, rsp_bad_addr}, 32'h0);
            if (sel != 0) begin
                mrg = (sel == 1) ? wd : ((old & ~mk) | (wd & mk));
                model[s] = (old & ~wm) | (mrg & wm);
            end
        end
    endtask

    task automatic rd(input logic [13:0] a, input string tag);
        do_op(5'd0, a, $urandom, $urandom, tag);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] hold;
        void'($urandom(32'h5EED_1234));
        for (int s = 0; s < 30; s++) model[s] = (s == 0) ? 32'h8 : 32'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R5 rdata after reset", rsp_rdata, 32'h0);
        chk("R5 flag after reset", {31'h0, rsp_bad_addr}, 32'h0);
        for (int s = 0; s < 30; s++) rd(b_addr(s), "R5 reset content");

        // R2/R10: all-ones writes reveal each mask, then read back
        for (int s = 0; s < 30; s++) do_op(5'd1, b_addr(s), 32'hFFFFFFFF, 32'h0, "R2 write ones");
        for (int s = 0; s < 30; s++) rd(b_addr(s), "R10 mask readback");

        // R6: read-only registers stay zero
        rd(14'h01B, "R6 dir sel"); rd(14'h020, "R6 core id");
        rd(14'h042, "R6 timer val"); rd(14'h098, "R6 cache tag");

        // R7: write-one bits read back zero
        do_op(5'd1, 14'h044, 32'h1, 32'h0, "R7 clear write");
        rd(14'h044, "R7 clear readback");
        do_op(5'd1, 14'h060, 32'h6, 32'h0, "R7 link write");
        rd(14'h060, "R7 link readback");

        // R3: exchange on scratch with a partial mask
        do_op(5'd1, 14'h030, 32'h1234_5678, 32'h0, "R2 scratch");
        do_op(5'd2, 14'h030, 32'hABCD_EF01, 32'hFF00_00F0, "R3 xchg");
        rd(14'h030, "R3 xchg result");
        do_op(5'd31, 14'h004, 32'h0, 32'h0000_0C03, "R3 xchg clear");
        rd(14'h004, "R3 exchange cfg");

        // R8/R9: invalid index, then idle cycle
        do_op(5'd1, 14'h003, 32'hFFFFFFFF, 32'hFFFFFFFF, "R8 invalid write");
        hold = rsp_rdata;
        @(negedge clk);
        chk("R9 idle flag low", {31'h0, rsp_bad_addr}, 32'h0);
        chk("R9 idle data held", rsp_rdata, hold);
        for (int s = 0; s < 30; s++) rd(b_addr(s), "R8 state unchanged");

        // Random mixed traffic against the model
        for (int i = 0; i < 3000; i++) begin
            logic [4:0]  sel;
            logic [13:0] a;
            int pick;
            pick = $urandom_range(0, 3);
            sel = (pick == 0) ? 5'd0 : (pick == 1) ? 5'd1 : 5'($urandom_range(2, 31));
            if ($urandom_range(0, 15) == 0) a = 14'h3FFF - 14'($urandom_range(0, 100));
            else a = b_addr($urandom_range(0, 29));
            do_op(sel, a, $urandom, $urandom, "R1 R2 R3 random");
        end
        for (int s = 0; s < 30; s++) rd(b_addr(s), "R4 final sweep");

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule